// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside the command path of a synchronous DRAM controller or device model. When a read or write command is accepted, it captures the starting column, a burst-length code and an ordering bit. From the following cycle it then presents one column address per clock, together with a valid flag and a flag that marks the final beat.

Fixed-length bursts of 1, 2, 4 or 8 beats never leave the aligned group of columns that holds the starting column. Only the low address bits move. They move either by modular increment (sequential order) or by XOR with a beat counter (interleaved order). A full-page burst steps through every column of the page, wraps from the top column back to zero, and runs until an explicit stop. A new start may arrive on any cycle and replaces whatever burst is in progress. Data transfer and bank selection belong to other blocks.

The column width `COL_W` sets the page size (2^COL_W columns) and must be at least 4.

Top module: `sdram_burst_colgen`

## Requirements
- R1: `len_code` selects the burst: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4, 5 and 6 are reserved: they give a single beat and set `mode_err`.
- R2: With `order`=0 (sequential), beat i of a fixed burst of length L is `(start & ~(L-1)) | ((start + i) mod L)`.
- R3: With `order`=1 (interleaved), beat i of a fixed burst of length L is `(start & ~(L-1)) | ((start ^ i) & (L-1))`. For example, L=8 with start 2 gives 2,3,0,1,6,7,4,5.
- R4: Every address of a fixed burst keeps the bits above the aligned L-column group equal to those of the start column.
- R5: A `start` sampled at a rising edge makes `col_valid` high in the next cycle, with `col_addr` equal to `start_col`. A fixed burst of length L gives L consecutive valid beats, and `col_valid` then falls unless another start arrives.
- R6: `col_last` is high on the final beat of a fixed burst and on no other beat.
- R7: A full-page burst increments the column by one each cycle modulo 2^COL_W. It never raises `col_last` and continues until stopped.
- R8: `stop` sampled high without `start` makes `col_valid` low from the next cycle.
- R9: `start` is accepted on any cycle, including during a burst or on its last beat. It takes priority over `stop` at the same edge, and the previous burst is abandoned.
- R10: Full page requested with `order`=1 runs in sequential order and sets `mode_err`. `mode_err` reflects the most recent start, so a legal start clears it.
- R11: While `rst` is high, and after it is released, `col_valid`, `col_last` and `mode_err` stay low until a start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command accepted: capture start column and mode |
| start_col | input | COL_W | Starting column address |
| len_code | input | 3 | Burst length code |
| order | input | 1 | 0 = sequential, 1 = interleaved |
| stop | input | 1 | Terminate the current burst |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Latest start requested an illegal mode |

## Verification
The bench builds the block with the default `COL_W` of 10, which gives a 1024-column page. With that width, a full-page burst started near the top of the page can run past column 1023 and back through zero within a short run, so the wrap and the absence of any final-beat flag can be observed directly. The 3-bit burst group sits well inside 10 bits, so starts near 1023 show that the upper bits stay put while the low bits wrap. At the ports, the bench also covers interrupting starts, stops in the middle of a burst, a start and a stop at the same edge, and the illegal-mode fallback.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    // width of the largest fixed burst group (8 columns)
    localparam int BLK_W = 3;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } bl_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } ord_e;

    typedef struct packed {
        blk_t mask;   // L-1 for fixed bursts
        logic page;   // full-page burst
        ord_e ord;    // effective ordering
        logic bad;    // illegal request seen
    } burst_cfg_t;

    function automatic blk_t code_to_mask(input logic [2:0] code);
        blk_t m;
        case (code)
            BL_TWO:   m = 3'b001;
            BL_FOUR:  m = 3'b011;
            BL_EIGHT: m = 3'b111;
            default:  m = 3'b000;
        endcase
        return m;
    endfunction

    function automatic blk_t wrap_low(input blk_t s, input blk_t c,
                                      input blk_t m, input ord_e o);
        blk_t op;
        op = (o == ORD_ILV) ? (s ^ c) : blk_t'(s + c);
        return (s & ~m) | (op & m);
    endfunction

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
    import sdram_burst_pkg::*;
(
    input  logic [2:0]  len_code,
    input  logic        order,
    output burst_cfg_t  cfg
);

    logic is_page;
    logic is_rsvd;

    assign is_page = (len_code == BL_PAGE);
    assign is_rsvd = (len_code == 3'd4) || (len_code == 3'd5) || (len_code == 3'd6);

    always_comb begin
        cfg.mask = code_to_mask(len_code);
        cfg.page = is_page;
        cfg.ord  = ord_e'(order);
        cfg.bad  = is_rsvd;
        if (is_page && order) begin
            cfg.ord = ORD_SEQ;
            cfg.bad = 1'b1;
        end
    end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    output logic             busy,
    output logic             last,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] base,
    output burst_cfg_t       cfg_q
);

    localparam logic [COL_W-1:0] CNT_ONE = COL_W'(1);

    assign last = busy && !cfg_q.page && (cnt == COL_W'(cfg_q.mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            base  <= '0;
            cfg_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            base  <= start_col;
            cfg_q <= cfg_in;
        end else if (stop) begin
            busy  <= 1'b0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end
            cnt <= cnt + CNT_ONE;
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !cfg_q.page |-> cnt <= COL_W'(cfg_q.mask));

endmodule

// File: rtl/burst_addr_form.sv
module burst_addr_form
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] addr
);

    localparam int HI_W = COL_W - BLK_W;

    logic [HI_W-1:0]  hi;
    blk_t             lo;
    logic [COL_W-1:0] page_addr;

    assign hi        = base[COL_W-1:BLK_W];
    assign lo        = wrap_low(base[BLK_W-1:0], cnt[BLK_W-1:0], cfg.mask, cfg.ord);
    assign page_addr = base + cnt;
    assign addr      = cfg.page ? page_addr : {hi, lo};

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             order,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             mode_err
);

    burst_cfg_t       cfg_dec;
    burst_cfg_t       cfg_cur;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;
    logic             busy;
    logic             last;

    burst_mode_decode u_dec (
        .len_code (len_code),
        .order    (order),
        .cfg      (cfg_dec)
    );

    burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .cfg_in    (cfg_dec),
        .busy      (busy),
        .last      (last),
        .cnt       (cnt),
        .base      (base),
        .cfg_q     (cfg_cur)
    );

    burst_addr_form #(.COL_W(COL_W)) u_form (
        .base (base),
        .cnt  (cnt),
        .cfg  (cfg_cur),
        .addr (col_addr)
    );

    assign col_valid = busy;
    assign col_last  = last;
    assign mode_err  = cfg_cur.bad;

    // R5
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> col_valid && col_addr == $past(start_col));

    // R6
    last_drop_chk: assert property (@(posedge clk) disable iff (rst)
        col_last && !start |=> !col_valid);

    // R8
    stop_end_chk: assert property (@(posedge clk) disable iff (rst)
        stop && !start |=> !col_valid);

    // R4
    block_hold_chk: assert property (@(posedge clk) disable iff (rst)
        col_valid && !col_last && !start && !stop && !cfg_cur.page |=>
            (col_addr >> BLK_W) == ($past(col_addr) >> BLK_W));

    // R7
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        col_valid && cfg_cur.page && !start && !stop |=>
            col_valid && !col_last && col_addr == $past(col_addr) + COL_W'(1));

    // R10
    bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
        start && len_code == 3'd7 && order |=> mode_err);

endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  CW         = 10;
    localparam int  PAGE       = 1 << CW;

    typedef struct {
        logic [CW-1:0] a;
        logic          l;
        string         tag;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] start_col = '0;
    logic [2:0]    len_code = '0;
    logic          order = 1'b0;
    logic          stop = 1'b0;
    logic [CW-1:0] col_addr;
    logic          col_valid;
    logic          col_last;
    logic          mode_err;

    int    total = 0;
    int    bad = 0;
    bit    ended = 0;
    beat_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(CW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .len_code  (len_code),
        .order     (order),
        .stop      (stop),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_last  (col_last),
        .mode_err  (mode_err)
    );

    function automatic int burst_len(input logic [2:0] code);
        if (code <= 3'd3) return 1 << code;
        if (code == 3'd7) return -1;
        return 1;
    endfunction

    function automatic logic [CW-1:0] exp_addr(input logic [CW-1:0] s, input int L,
                                               input bit ilv, input int i);
        int b;
        int lo;
        if (L < 0) return CW'((int'(s) + i) % PAGE);
        b  = int'(s) & ~(L - 1);
        lo = ilv ? ((int'(s) ^ i) & (L - 1)) : ((int'(s) + i) % L);
        return CW'(b | lo);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compare every visible beat with the scoreboard
    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (col_valid) begin
                if (expq.size() == 0) begin
                    check(0, "R5 unexpected beat", int'(col_addr), -1);
                end else begin
                    beat_t e;
                    e = expq.pop_front();
                    check(col_addr == e.a, {e.tag, " addr"}, int'(col_addr), int'(e.a));
                    check(col_last == e.l, "R6 last flag", int'(col_last), int'(e.l));
                end
            end else if (expq.size() != 0) begin
                check(0, "R5 missing beat", 0, 1);
            end
        end
    end

    // mode: 0 runs to its end, 1 stops after keep beats, 2 lets the next start cut in
    task automatic burst(input logic [CW-1:0] s, input logic [2:0] code, input logic ord,
                         input int keep, input int mode, input logic with_stop,
                         input logic exp_err, input string tag);
        int  L;
        int  n;
        bit  ilv;
        L   = burst_len(code);
        ilv = ord && (L > 0);
        n   = (mode == 0) ? L : keep;
        start     = 1'b1;
        start_col = s;
        len_code  = code;
        order     = ord;
        stop      = with_stop;
        @(negedge clk); #1;
        expq.delete();
        for (int i = 0; i < n; i++) begin
            beat_t b;
            b.a   = exp_addr(s, L, ilv, i);
            b.l   = (L > 0) && (i == L - 1);
            b.tag = tag;
            expq.push_back(b);
        end
        @(posedge clk); #1;
        start = 1'b0;
        stop  = 1'b0;
        check(mode_err == exp_err, "R10 mode_err", int'(mode_err), int'(exp_err));
        repeat (n - 1) begin
            @(posedge clk); #1;
        end
        if (mode == 1) begin
            stop = 1'b1;
            @(posedge clk); #1;
            stop = 1'b0;
            repeat (2) begin
                @(posedge clk); #1;
            end
        end else if (mode == 0) begin
            repeat (2) begin
                @(posedge clk); #1;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check(!col_valid, "R11 valid in reset", int'(col_valid), 0);
        check(!col_last,  "R11 last in reset",  int'(col_last), 0);
        check(!mode_err,  "R11 err in reset",   int'(mode_err), 0);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(!col_valid, "R11 valid after reset", int'(col_valid), 0);

        // R3: documented interleave example 2,3,0,1,6,7,4,5
        burst(10'd2, 3'd3, 1'b1, 0, 0, 1'b0, 1'b0, "R3 ilv8");
        // R2 R4: sequential 8 wrapping inside group 8..15
        burst(10'd13, 3'd3, 1'b0, 0, 0, 1'b0, 1'b0, "R2 seq8");
        burst(10'd6, 3'd2, 1'b0, 0, 0, 1'b0, 1'b0, "R2 seq4");
        burst(10'd9, 3'd1, 1'b1, 0, 0, 1'b0, 1'b0, "R3 ilv2");
        // R1: single beat
        burst(10'd100, 3'd0, 1'b1, 0, 0, 1'b0, 1'b0, "R1 len1");
        // R4: top of page, upper bits must hold
        burst(10'd1023, 3'd2, 1'b1, 0, 0, 1'b0, 1'b0, "R4 ilv4 top");
        burst(10'd1021, 3'd3, 1'b0, 0, 0, 1'b0, 1'b0, "R4 seq8 top");
        // R7: full page wraps past 1023, stopped after 1030 beats
        burst(10'd1020, 3'd7, 1'b0, 1030, 1, 1'b0, 1'b0, "R7 page");
        // R10: full page with interleave falls back to sequential
        burst(10'd500, 3'd7, 1'b1, 10, 1, 1'b0, 1'b1, "R10 page fallback");
        // R1: reserved code gives one beat and an error
        burst(10'd77, 3'd5, 1'b0, 0, 0, 1'b0, 1'b1, "R1 reserved");
        // R8: stop in the middle of a fixed burst
        burst(10'd40, 3'd3, 1'b1, 3, 1, 1'b0, 1'b0, "R8 stop mid");
        // R9: interrupt after 3 beats, then a start on the last beat
        burst(10'd16, 3'd3, 1'b0, 3, 2, 1'b0, 1'b0, "R9 cut");
        burst(10'd33, 3'd2, 1'b1, 4, 2, 1'b0, 1'b0, "R9 on last");
        burst(10'd250, 3'd1, 1'b0, 0, 0, 1'b0, 1'b0, "R9 follow");
        // R9: start wins over stop at the same edge
        burst(10'd57, 3'd2, 1'b0, 0, 0, 1'b1, 1'b0, "R9 start over stop");

        check(expq.size() == 0, "R5 leftover beats", expq.size(), 0);
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule